// File: doc/BRIEF.md
# Pre-Adder Multiply-Accumulate Slice

This block is a purely combinational arithmetic slice. It first adds or subtracts two 18-bit signed inputs, B and D. It then multiplies that pre-sum by a third 18-bit signed input, A. Finally it combines the product with a 48-bit constant operand, a carry-in bit and a 48-bit feedback operand. The feedback operand comes from one of three places: the cascade input from a neighbouring slice, the slice's own previously registered result, or zero. It can be shifted arithmetically right by 17 positions before use, which lets slices be chained into wider multiplies. The slice drives a 48-bit result, a cascade copy of that result, and one status flag. A static select makes the flag report either signed overflow or carry-out.

Two static mode pins repurpose the multiplier. Split mode cuts each 18-bit input into two 9-bit lanes and returns two independent products, one in each 24-bit half of the result. Dot mode adds the two lane products together and feeds that sum through the normal accumulate path. The slice holds no registers. The integrator owns all pipelining, including the register whose output is wired back to `feedbackIn`.

Top module: `premac_slice`

## Requirements
- R1: The pre-sum is the signed value B - D when `preSubIn` is 1, and B + D when `preSubIn` is 0. It is computed without loss in 19 bits.
- R2: In normal mode (both mode pins 0), `pOut` = Ex + M + C + `carryIn`, truncated to 48 bits. M is A × pre-sum when `subIn` is 0 and its negation when `subIn` is 1. All arithmetic is signed two's complement.
- R3: `eSelIn` picks the feedback operand Ex: 2'b00 gives zero, 2'b01 gives `feedbackIn`, 2'b10 gives `cascadeIn`, and 2'b11 gives zero.
- R4: When `shiftEIn` is 1, the chosen operand is shifted arithmetically right by 17 bits before it is added.
- R5: `cascadeOut` always equals `pOut`.
- R6: Let S be the exact 50-bit signed sum. When `flagSelCarry` is 0, `flagOut` is 1 exactly when S[49:47] are not all equal. When `flagSelCarry` is 1, `flagOut` is S[48].
- R7: With `simdMode` = 1, `pOut[23:0]` is the sign-extended product A[8:0] × (B[8:0] ± D[8:0]), and `pOut[47:24]` is the same for bits 17:9. The sign is chosen by `preSubIn`. C, `carryIn`, `subIn`, `eSelIn` and `shiftEIn` have no effect, and `flagOut` is 0.
- R8: With `dotMode` = 1, M in R2 is formed from the sum of the two lane products defined in R7 instead of the 18-bit product. The rest of R2, R3, R4 and R6 still applies.
- R9: `simdMode` and `dotMode` are never both 1. If they are, split mode takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aIn | input | 18 | Signed multiplier operand A |
| bIn | input | 18 | Signed pre-adder operand B |
| dIn | input | 18 | Signed pre-adder operand D |
| cIn | input | 48 | Signed additive operand C |
| carryIn | input | 1 | Carry added to the sum |
| cascadeIn | input | 48 | Result of an upstream slice |
| feedbackIn | input | 48 | Registered result of this slice |
| preSubIn | input | 1 | 1: B - D, 0: B + D |
| subIn | input | 1 | 1: subtract the product term |
| eSelIn | input | 2 | Feedback operand source select |
| shiftEIn | input | 1 | Arithmetic right shift by 17 of the feedback operand |
| simdMode | input | 1 | Static: two independent 9-bit products |
| dotMode | input | 1 | Static: sum of two 9-bit products |
| flagSelCarry | input | 1 | Static: 1 reports carry-out, 0 reports overflow |
| pOut | output | 48 | Result |
| cascadeOut | output | 48 | Copy of the result for a downstream slice |
| flagOut | output | 1 | Overflow or carry-out flag |

## Verification
The checks assume that the two mode pins are never raised together. The no-overflow check further assumes that, with C zero and no feedback operand, a product of at most 37 bits can never leave the 48-bit range. The split-mode zero check relies on C, the feedback operand and the shift being ignored in that mode, and that is also the only legal way to drive them there. For this reason, random split-mode stimulus holds D[8:0], C, the select and the shift at zero. Dot and normal stimulus never set both mode pins.

// File: rtl/premac_pkg.sv
package premac_pkg;

  typedef enum logic [1:0] {
    E_ZERO     = 2'b00,
    E_FEEDBACK = 2'b01,
    E_CASCADE  = 2'b10,
    E_ZERO_ALT = 2'b11
  } eSrc_t;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'b00,
    MODE_SPLIT = 2'b01,
    MODE_DOT   = 2'b10
  } mode_t;

  typedef struct packed {
    mode_t mode;
    logic  preSub;
    logic  finalSub;
    eSrc_t eSrc;
    logic  shiftE;
    logic  flagCarry;
  } strobes_t;

endpackage

// File: rtl/premac_ctrl.sv
module premac_ctrl
  import premac_pkg::*;
(
  input  logic       simdMode,
  input  logic       dotMode,
  input  logic       preSubIn,
  input  logic       subIn,
  input  logic [1:0] eSelIn,
  input  logic       shiftEIn,
  input  logic       flagSelCarry,
  output strobes_t   strobes
);

  always_comb begin
    strobes.preSub    = preSubIn;
    strobes.flagCarry = flagSelCarry;
    strobes.finalSub  = subIn;
    strobes.eSrc      = eSrc_t'(eSelIn);
    strobes.shiftE    = shiftEIn;
    if (simdMode) begin
      // split lanes ignore the accumulate controls
      strobes.mode     = MODE_SPLIT;
      strobes.finalSub = 1'b0;
      strobes.eSrc     = E_ZERO;
      strobes.shiftE   = 1'b0;
    end else if (dotMode) begin
      strobes.mode = MODE_DOT;
    end else begin
      strobes.mode = MODE_FULL;
    end
  end

endmodule

// File: rtl/premac_datapath.sv
module premac_datapath
  import premac_pkg::*;
#(
  parameter int IN_W    = 18,
  parameter int OUT_W   = 48,
  parameter int SHIFT_W = 17
) (
  input  strobes_t           strobes,
  input  logic [IN_W-1:0]    aIn,
  input  logic [IN_W-1:0]    bIn,
  input  logic [IN_W-1:0]    dIn,
  input  logic [OUT_W-1:0]   cIn,
  input  logic               carryIn,
  input  logic [OUT_W-1:0]   cascadeIn,
  input  logic [OUT_W-1:0]   feedbackIn,
  output logic [OUT_W-1:0]   pOut,
  output logic               flagOut
);

  localparam int NLANES      = 2;
  localparam int LANE_W      = IN_W / NLANES;
  localparam int PRE_W       = IN_W + 1;
  localparam int PROD_W      = IN_W + PRE_W;
  localparam int LANE_PRE_W  = LANE_W + 1;
  localparam int LANE_PROD_W = LANE_W + LANE_PRE_W;
  localparam int DOT_W       = LANE_PROD_W + 1;
  localparam int SUM_W       = OUT_W + 2;
  localparam int HALF_W      = OUT_W / NLANES;

  // full-width pre-adder and multiplier
  logic signed [PRE_W-1:0]  preSum;
  logic signed [PROD_W-1:0] aExt;
  logic signed [PROD_W-1:0] preExt;
  logic signed [PROD_W-1:0] fullProd;

  always_comb begin
    if (strobes.preSub)
      preSum = $signed({bIn[IN_W-1], bIn}) - $signed({dIn[IN_W-1], dIn});
    else
      preSum = $signed({bIn[IN_W-1], bIn}) + $signed({dIn[IN_W-1], dIn});
    aExt     = $signed({{PRE_W{aIn[IN_W-1]}}, aIn});
    preExt   = $signed({{IN_W{preSum[PRE_W-1]}}, preSum});
    fullProd = aExt * preExt;
  end

  // narrow lanes, shared by split and dot modes
  logic signed [LANE_PROD_W-1:0] laneProd [NLANES];
  logic        [OUT_W-1:0]       splitP;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE_W-1:0]             aL, bL, dL;
    logic signed [LANE_PRE_W-1:0]  preL;
    logic signed [LANE_PROD_W-1:0] aLx, preLx;
    always_comb begin
      aL = aIn[g*LANE_W +: LANE_W];
      bL = bIn[g*LANE_W +: LANE_W];
      dL = dIn[g*LANE_W +: LANE_W];
      if (strobes.preSub)
        preL = $signed({bL[LANE_W-1], bL}) - $signed({dL[LANE_W-1], dL});
      else
        preL = $signed({bL[LANE_W-1], bL}) + $signed({dL[LANE_W-1], dL});
      aLx   = $signed({{LANE_PRE_W{aL[LANE_W-1]}}, aL});
      preLx = $signed({{LANE_W{preL[LANE_PRE_W-1]}}, preL});
      laneProd[g] = aLx * preLx;
    end
    assign splitP[g*HALF_W +: HALF_W] =
      {{(HALF_W-LANE_PROD_W){laneProd[g][LANE_PROD_W-1]}}, laneProd[g]};
  end

  logic signed [DOT_W-1:0] dotSum;

  always_comb begin
    dotSum = '0;
    for (int k = 0; k < NLANES; k++)
      dotSum = dotSum + $signed({laneProd[k][LANE_PROD_W-1], laneProd[k]});
  end

  // feedback operand select and shift
  logic [OUT_W-1:0] eRaw;
  logic [OUT_W-1:0] eShift;

  always_comb begin
    unique case (strobes.eSrc)
      E_FEEDBACK: eRaw = feedbackIn;
      E_CASCADE:  eRaw = cascadeIn;
      E_ZERO,
      E_ZERO_ALT: eRaw = '0;
      default:    eRaw = '0;
    endcase
    if (strobes.shiftE)
      eShift = $unsigned($signed(eRaw) >>> SHIFT_W);
    else
      eShift = eRaw;
  end

  // final 50-bit accumulate
  logic signed [SUM_W-1:0] term;
  logic signed [SUM_W-1:0] termSigned;
  logic signed [SUM_W-1:0] sumFull;
  logic        [2:0]       topBits;

  always_comb begin
    if (strobes.mode == MODE_DOT)
      term = $signed({{(SUM_W-DOT_W){dotSum[DOT_W-1]}}, dotSum});
    else
      term = $signed({{(SUM_W-PROD_W){fullProd[PROD_W-1]}}, fullProd});
    termSigned = strobes.finalSub ? -term : term;
    sumFull = $signed({{(SUM_W-OUT_W){eShift[OUT_W-1]}}, eShift})
            + termSigned
            + $signed({{(SUM_W-OUT_W){cIn[OUT_W-1]}}, cIn})
            + $signed({{(SUM_W-1){1'b0}}, carryIn});
    topBits = sumFull[SUM_W-1:OUT_W-1];
  end

  always_comb begin
    if (strobes.mode == MODE_SPLIT) begin
      pOut    = splitP;
      flagOut = 1'b0;
    end else begin
      pOut = sumFull[OUT_W-1:0];
      if (strobes.flagCarry)
        flagOut = sumFull[OUT_W];
      else
        flagOut = !((&topBits) || (~|topBits));
    end
  end

endmodule

// File: rtl/premac_slice.sv
module premac_slice
  import premac_pkg::*;
#(
  parameter int IN_W    = 18,
  parameter int OUT_W   = 48,
  parameter int SHIFT_W = 17
) (
  input  logic [IN_W-1:0]  aIn,
  input  logic [IN_W-1:0]  bIn,
  input  logic [IN_W-1:0]  dIn,
  input  logic [OUT_W-1:0] cIn,
  input  logic             carryIn,
  input  logic [OUT_W-1:0] cascadeIn,
  input  logic [OUT_W-1:0] feedbackIn,
  input  logic             preSubIn,
  input  logic             subIn,
  input  logic [1:0]       eSelIn,
  input  logic             shiftEIn,
  input  logic             simdMode,
  input  logic             dotMode,
  input  logic             flagSelCarry,
  output logic [OUT_W-1:0] pOut,
  output logic [OUT_W-1:0] cascadeOut,
  output logic             flagOut
);

  strobes_t strobes;

  premac_ctrl u_ctrl (
    .simdMode    (simdMode),
    .dotMode     (dotMode),
    .preSubIn    (preSubIn),
    .subIn       (subIn),
    .eSelIn      (eSelIn),
    .shiftEIn    (shiftEIn),
    .flagSelCarry(flagSelCarry),
    .strobes     (strobes)
  );

  premac_datapath #(
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .SHIFT_W(SHIFT_W)
  ) u_dp (
    .strobes   (strobes),
    .aIn       (aIn),
    .bIn       (bIn),
    .dIn       (dIn),
    .cIn       (cIn),
    .carryIn   (carryIn),
    .cascadeIn (cascadeIn),
    .feedbackIn(feedbackIn),
    .pOut      (pOut),
    .flagOut   (flagOut)
  );

  assign cascadeOut = pOut;

endmodule

// File: rtl/premac_checker.sv
module premac_checker #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 48
) (
  input logic [IN_W-1:0]  aIn,
  input logic [OUT_W-1:0] cIn,
  input logic             carryIn,
  input logic [1:0]       eSelIn,
  input logic             simdMode,
  input logic             dotMode,
  input logic             flagSelCarry,
  input logic [OUT_W-1:0] pOut,
  input logic [OUT_W-1:0] cascadeOut,
  input logic             flagOut
);

  logic noFeedback;
  assign noFeedback = (eSelIn == 2'b00) || (eSelIn == 2'b11);

  always_comb begin
    // R5
    cascade_mirror_chk: assert (cascadeOut == pOut);
    // R9
    mode_exclusive_chk: assert (!(simdMode && dotMode));
    // R2
    if (!simdMode && !dotMode && aIn == '0 && cIn == '0 && !carryIn && noFeedback)
      zero_product_chk: assert (pOut == '0);
    // R6
    if (!simdMode && !dotMode && cIn == '0 && noFeedback && !flagSelCarry)
      no_overflow_chk: assert (!flagOut);
    // R7
    if (simdMode && aIn == '0)
      split_zero_chk: assert (pOut == '0 && !flagOut);
  end

endmodule

bind premac_slice premac_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .aIn         (aIn),
  .cIn         (cIn),
  .carryIn     (carryIn),
  .eSelIn      (eSelIn),
  .simdMode    (simdMode),
  .dotMode     (dotMode),
  .flagSelCarry(flagSelCarry),
  .pOut        (pOut),
  .cascadeOut  (cascadeOut),
  .flagOut     (flagOut)
);

// File: tb/premac_slice_bench.sv
module premac_slice_bench;

  typedef struct packed {
    logic [1:0]  mode;   // 0 normal, 1 split, 2 dot
    logic [17:0] a, b, d;
    logic [47:0] c, cd, fb;
    logic        cy, ps, sb;
    logic [1:0]  es;
    logic        sh, fs;
    logic [47:0] expP;
    logic        expF;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    // R2 plain accumulate: 3*(4+5)+10+1
    '{2'd0, 18'd3, 18'd4, 18'd5, 48'd10, 48'd0, 48'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 48'd38, 1'b0},
    // R1 pre-subtract: 3*(4-5)+10
    '{2'd0, 18'd3, 18'd4, 18'd5, 48'd10, 48'd0, 48'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 48'd7, 1'b0},
    // R2 final subtract: 100-2*6
    '{2'd0, 18'd2, 18'd6, 18'd0, 48'd100, 48'd0, 48'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 48'd88, 1'b0},
    // R3 feedback source
    '{2'd0, 18'd1, 18'd1, 18'd0, 48'd0, 48'd0, 48'd1000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 48'd1001, 1'b0},
    // R3 cascade source, negative A
    '{2'd0, 18'h3FFFF, 18'd10, 18'd0, 48'd0, 48'd500, 48'd0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 48'd490, 1'b0},
    // R3 select 3 gives zero
    '{2'd0, 18'd0, 18'd0, 18'd0, 48'd7, 48'd500, 48'd0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 48'd7, 1'b0},
    // R4 shift 2^17 down to 1
    '{2'd0, 18'd0, 18'd0, 18'd0, 48'd0, 48'h20000, 48'd0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 48'd1, 1'b0},
    // R8 dot 3*5+2*4+1+1
    '{2'd2, 18'h00403, 18'h00805, 18'd0, 48'd1, 48'd0, 48'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 48'd25, 1'b0},
    // R7 split lanes 15 and 8
    '{2'd1, 18'h00403, 18'h00805, 18'd0, 48'd0, 48'd0, 48'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 48'h000008_00000F, 1'b0},
    // R6 carry-out: -2^47 + -2^47
    '{2'd0, 18'd0, 18'd0, 18'd0, 48'h8000_0000_0000, 48'h8000_0000_0000, 48'd0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 48'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [17:0] aIn, bIn, dIn;
  logic [47:0] cIn, cascadeIn, feedbackIn;
  logic        carryIn, preSubIn, subIn, shiftEIn, simdMode, dotMode, flagSelCarry;
  logic [1:0]  eSelIn;
  logic [47:0] pOut, cascadeOut;
  logic        flagOut;

  premac_slice u_premac_slice (
    .aIn(aIn), .bIn(bIn), .dIn(dIn), .cIn(cIn), .carryIn(carryIn),
    .cascadeIn(cascadeIn), .feedbackIn(feedbackIn), .preSubIn(preSubIn),
    .subIn(subIn), .eSelIn(eSelIn), .shiftEIn(shiftEIn), .simdMode(simdMode),
    .dotMode(dotMode), .flagSelCarry(flagSelCarry), .pOut(pOut),
    .cascadeOut(cascadeOut), .flagOut(flagOut)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  function automatic longint laneRef(logic [8:0] a9, logic [8:0] b9, logic [8:0] d9, logic ps);
    longint bb = longint'($signed(b9));
    longint dd = longint'($signed(d9));
    return longint'($signed(a9)) * (ps ? bb - dd : bb + dd);
  endfunction

  function automatic logic [48:0] refModel(vec_t v);
    longint l0, l1, prod, e, total, bb, dd;
    logic [63:0] s;
    logic [47:0] p;
    logic        f;
    l0 = laneRef(v.a[8:0], v.b[8:0], v.d[8:0], v.ps);
    l1 = laneRef(v.a[17:9], v.b[17:9], v.d[17:9], v.ps);
    if (v.mode == 2'd1) begin
      p = {l1[23:0], l0[23:0]};
      f = 1'b0;
    end else begin
      bb = longint'($signed(v.b));
      dd = longint'($signed(v.d));
      if (v.mode == 2'd2) prod = l0 + l1;
      else                prod = longint'($signed(v.a)) * (v.ps ? bb - dd : bb + dd);
      case (v.es)
        2'd1:    e = longint'($signed(v.fb));
        2'd2:    e = longint'($signed(v.cd));
        default: e = 0;
      endcase
      if (v.sh) e = e >>> 17;
      total = e + (v.sb ? -prod : prod) + longint'($signed(v.c)) + longint'(v.cy);
      s = total;
      p = s[47:0];
      if (v.fs) f = s[48];
      else      f = !((s[49:47] == 3'b000) || (s[49:47] == 3'b111));
    end
    return {f, p};
  endfunction

  task automatic drive(vec_t v);
    @(negedge clk);
    aIn = v.a; bIn = v.b; dIn = v.d; cIn = v.c; cascadeIn = v.cd; feedbackIn = v.fb;
    carryIn = v.cy; preSubIn = v.ps; subIn = v.sb; eSelIn = v.es; shiftEIn = v.sh;
    flagSelCarry = v.fs; simdMode = (v.mode == 2'd1); dotMode = (v.mode == 2'd2);
    #2;
  endtask

  task automatic check(string tag, logic [47:0] expP, logic expF);
    nChecks++;
    if (pOut !== expP || flagOut !== expF || cascadeOut !== expP) begin
      nFails++;
      $display("FAIL %s: p=%h flag=%b cascade=%h expected p=%h flag=%b",
               tag, pOut, flagOut, cascadeOut, expP, expF);
    end
  endtask

  function automatic vec_t blank();
    vec_t v = '0;
    return v;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    vec_t v;
    logic [48:0] r;

    // R2 quiet state: all inputs zero
    v = blank();
    drive(v);
    check("R2 zero inputs", 48'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      check($sformatf("R5 table entry %0d", i), VECS[i].expP, VECS[i].expF);
    end

    // R6 overflow at positive limit, then carry view of the same sum
    v = blank(); v.cd = 48'h7FFF_FFFF_FFFF; v.c = 48'd1; v.es = 2'd2;
    drive(v);
    check("R6 overflow", 48'h8000_0000_0000, 1'b1);
    v.fs = 1'b1;
    drive(v);
    check("R6 carry view", 48'h8000_0000_0000, 1'b0);

    // R4 shift keeps sign
    v = blank(); v.cd = 48'h8000_0000_0000; v.es = 2'd2; v.sh = 1'b1;
    drive(v);
    check("R4 negative shift", 48'hFFFF_C000_0000, 1'b0);

    // R1 negative pre-difference
    v = blank(); v.a = 18'd2; v.b = 18'd5; v.d = 18'd7; v.ps = 1'b1;
    drive(v);
    check("R1 pre-subtract", 48'hFFFF_FFFF_FFFC, 1'b0);

    // R3 unused cascade value under select 0
    v = blank(); v.cd = 48'd123; v.fb = 48'd77; v.es = 2'd0;
    drive(v);
    check("R3 select zero", 48'd0, 1'b0);
    v.es = 2'd1;
    drive(v);
    check("R3 select feedback", 48'd77, 1'b0);

    // R7 R9 signed lanes, then accumulate controls ignored
    v = blank(); v.mode = 2'd1; v.a = 18'h005FF; v.b = 18'h00A03; v.d = 18'h00200;
    drive(v);
    check("R7 split signed", 48'h00000C_FFFFFD, 1'b0);
    v.sb = 1'b1; v.cd = 48'd999; v.es = 2'd2; v.sh = 1'b1; v.cy = 1'b1; v.fs = 1'b1;
    drive(v);
    check("R7 split ignores accumulate", 48'h00000C_FFFFFD, 1'b0);

    // R8 dot with negative lane, add then subtract
    v = blank(); v.mode = 2'd2; v.a = 18'h3FC03; v.b = 18'h00A04; v.c = 48'd1; v.cy = 1'b1;
    drive(v);
    check("R8 dot add", 48'd4, 1'b0);
    v.sb = 1'b1;
    drive(v);
    check("R8 dot subtract", 48'd0, 1'b0);

    // R2 R7 R8 random against the model
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 150; n++) begin
        v = blank();
        v.mode = 2'(m);
        v.a  = 18'($urandom);
        v.b  = 18'($urandom);
        v.d  = 18'($urandom);
        v.ps = 1'($urandom);
        v.fs = 1'($urandom);
        if (m != 1) begin
          v.c  = {16'($urandom), 32'($urandom)};
          v.cd = {16'($urandom), 32'($urandom)};
          v.fb = {16'($urandom), 32'($urandom)};
          v.cy = 1'($urandom);
          v.sb = 1'($urandom);
          v.es = 2'($urandom);
          v.sh = 1'($urandom);
        end else begin
          v.d[8:0] = '0;
        end
        r = refModel(v);
        drive(v);
        check($sformatf("R2 R7 R8 random mode %0d", m), r[47:0], r[48]);
      end
    end

    finish();
  end

endmodule